// File: doc/BRIEF.md
# Serial flash command launch decoder

This block decides the moment at which a queued serial-flash command in indirect mode is launched. Software programs a command through a handful of registers: an instruction field, an address register, an alternate-byte register and a data register. The block watches the write port of those registers. It combines the register being written with three configuration fields: whether an address phase exists, whether a data phase exists, and whether the transfer is an indirect write or an indirect read. From these it finds the one register whose write supplies the last missing piece of the command.

When that register is written and no command is in flight, the block issues a one-clock start pulse to the serial engine and raises a busy flag. It also captures the three mode fields, so the engine sees a stable configuration for the whole transfer. Busy falls when the engine reports that the transfer is complete. Qualifying writes that arrive while busy is high are ignored.

Top module: `flash_cmd_launch`

## Requirements
- R1: With address mode 00 and no firmware data needed (functional mode not 00, or data mode 00), a write to the instruction field (select 0) launches the command.
- R2: With address mode other than 00 and no firmware data needed, a write to the address register (select 1) launches the command.
- R3: With address mode other than 00, functional mode 00 (indirect write) and data mode other than 00, a write to the data register (select 3) launches the command.
- R4: A write to the alternate-byte register (select 2) never launches a command, in any mode.
- R5: `start` is high for exactly one clock, in the cycle after the launching write, and `busy` goes high in that same cycle.
- R6: `busy` stays high until `xfer_done` is sampled high while busy, and it is low from the following cycle. `xfer_done` has no effect while idle.
- R7: A write that would launch a command is ignored while `busy` is high: there is no start pulse and the captured modes do not change.
- R8: The captured mode outputs take the mode inputs present at the launching write. Later changes to the mode inputs do not alter them until the next launch.
- R9: With address mode 00, functional mode 00 and data mode other than 00, a write to the data register (select 3) launches the command.
- R10: Reset clears `start`, `busy` and the captured mode outputs to zero.
- R11: A write to a register other than the one selected by R1, R2, R3 or R9 does not launch a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 instruction, 1 address, 2 alternate bytes, 3 data |
| adr_mode | input | 2 | Address phase mode, 00 means no address phase |
| dat_mode | input | 2 | Data phase mode, 00 means no data phase |
| fn_mode | input | 2 | Functional mode, 00 indirect write, 01 indirect read |
| xfer_done | input | 1 | Transfer complete from the serial engine |
| start | output | 1 | One-clock command launch pulse |
| busy | output | 1 | Command in flight |
| cmd_adr_mode | output | 2 | Address mode captured at launch |
| cmd_dat_mode | output | 2 | Data mode captured at launch |
| cmd_fn_mode | output | 2 | Functional mode captured at launch |

## Verification
Every output sits behind one register. A write presented before clock edge k therefore shows its start pulse, busy rise and captured modes right after edge k, and a `xfer_done` pulse before edge k clears busy after the same edge. The driver applies each stimulus on a falling edge and queues the expected outputs once the next rising edge has passed. The monitor pops and compares them on the falling edge that follows, so every comparison lands exactly one register stage after its stimulus. Extra idle cycles are queued as well, to confirm that the pulse has dropped and that busy and the captured modes hold.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int SEL_W  = 2;
  localparam int MODE_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_INSTR = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_ALT   = 2'd2,
    SEL_DATA  = 2'd3
  } reg_sel_e;

  localparam logic [MODE_W-1:0] FN_IND_WRITE = '0;
  localparam logic [MODE_W-1:0] MODE_NONE    = '0;

  typedef struct packed {
    logic [MODE_W-1:0] adr;
    logic [MODE_W-1:0] dat;
    logic [MODE_W-1:0] fn;
  } cmd_modes_t;

endpackage

// File: rtl/cmd_trig_decode.sv
module cmd_trig_decode
  import flash_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  cmd_modes_t       modes,
  input  logic             busy,
  output logic             fire
);

  logic     need_addr;
  logic     need_data;
  reg_sel_e trig_sel;

  always_comb begin
    need_addr = (modes.adr != MODE_NONE);
    need_data = (modes.fn == FN_IND_WRITE) && (modes.dat != MODE_NONE);
    if (need_data)      trig_sel = SEL_DATA;
    else if (need_addr) trig_sel = SEL_ADDR;
    else                trig_sel = SEL_INSTR;
  end

  always_comb begin
    fire = wr_en && !busy && (wr_sel == trig_sel);
  end

  // R4: the alternate-byte register never launches
  a_r4_alt_never_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_ALT) |-> !fire);

  // R7: nothing launches while a command is in flight
  a_r7_no_fire_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !fire);

endmodule

// File: rtl/cmd_busy_ctrl.sv
module cmd_busy_ctrl
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       xfer_done,
  input  cmd_modes_t modes_in,
  output logic       start,
  output logic       busy,
  output cmd_modes_t modes_held
);

  logic       start_d, start_q;
  logic       busy_d, busy_q;
  logic       mode_en;
  cmd_modes_t modes_q;

  always_comb begin
    start_d = fire;
    busy_d  = busy_q;
    if (fire)           busy_d = 1'b1;
    else if (xfer_done) busy_d = 1'b0;
    mode_en = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      busy_q  <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modes_q <= '0;
    end else if (mode_en) begin
      modes_q <= modes_in;
    end
  end

  assign start      = start_q;
  assign busy       = busy_q;
  assign modes_held = modes_q;

  // R5: start is a single-cycle pulse
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R5: busy is high whenever start is
  a_r5_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);

  // R5: busy only rises together with a start pulse
  a_r5_busy_rise_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> start);

  // R6: busy holds until completion is reported
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> busy);

  // R6: completion while busy clears it
  a_r6_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done) |=> !busy);

  // R8: captured modes stay put unless a launch occurs
  a_r8_modes_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(modes_held));

endmodule

// File: rtl/flash_cmd_launch.sv
module flash_cmd_launch
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [MODE_W-1:0] adr_mode,
  input  logic [MODE_W-1:0] dat_mode,
  input  logic [MODE_W-1:0] fn_mode,
  input  logic              xfer_done,
  output logic              start,
  output logic              busy,
  output logic [MODE_W-1:0] cmd_adr_mode,
  output logic [MODE_W-1:0] cmd_dat_mode,
  output logic [MODE_W-1:0] cmd_fn_mode
);

  cmd_modes_t modes_now;
  cmd_modes_t modes_held;
  logic       fire;
  logic       busy_int;

  always_comb begin
    modes_now.adr = adr_mode;
    modes_now.dat = dat_mode;
    modes_now.fn  = fn_mode;
  end

  cmd_trig_decode u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .modes  (modes_now),
    .busy   (busy_int),
    .fire   (fire)
  );

  cmd_busy_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .xfer_done  (xfer_done),
    .modes_in   (modes_now),
    .start      (start),
    .busy       (busy_int),
    .modes_held (modes_held)
  );

  assign busy         = busy_int;
  assign cmd_adr_mode = modes_held.adr;
  assign cmd_dat_mode = modes_held.dat;
  assign cmd_fn_mode  = modes_held.fn;

  // R10: after reset release nothing is launched without a write
  a_r10_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !start);

endmodule

// File: tb/tb_flash_cmd_launch.sv
`timescale 1ns/1ps
module tb_flash_cmd_launch;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [1:0] adr_mode, dat_mode, fn_mode;
  logic       xfer_done;
  logic       start, busy;
  logic [1:0] cmd_adr_mode, cmd_dat_mode, cmd_fn_mode;

  flash_cmd_launch dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .adr_mode(adr_mode), .dat_mode(dat_mode), .fn_mode(fn_mode),
    .xfer_done(xfer_done), .start(start), .busy(busy),
    .cmd_adr_mode(cmd_adr_mode), .cmd_dat_mode(cmd_dat_mode),
    .cmd_fn_mode(cmd_fn_mode)
  );

  typedef struct {
    logic       st;
    logic       bz;
    logic [5:0] md;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         errors = 0;
  int         checks = 0;
  logic       m_busy;
  logic [5:0] m_modes;
  bit         done_flag = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Monitor: compares queued expectations on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t e;
        logic [5:0] got;
        e   = sb.pop_front();
        got = {cmd_adr_mode, cmd_dat_mode, cmd_fn_mode};
        checks++;
        if (start !== e.st || busy !== e.bz || got !== e.md) begin
          errors++;
          $display("FAIL %s: start=%b busy=%b modes=%h expected start=%b busy=%b modes=%h",
                   e.tag, start, busy, got, e.st, e.bz, e.md);
        end
      end
    end
  end

  task automatic push(input logic st, input string tag);
    exp_t e;
    e.st = st; e.bz = m_busy; e.md = m_modes; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic set_modes(input logic [1:0] a, input logic [1:0] d, input logic [1:0] f);
    @(negedge clk);
    adr_mode = a; dat_mode = d; fn_mode = f;
  endtask

  task automatic wr(input logic [1:0] sel, input logic exp_start, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel;
    @(posedge clk);
    if (exp_start) begin
      m_busy  = 1'b1;
      m_modes = {adr_mode, dat_mode, fn_mode};
    end
    push(exp_start, tag);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    @(posedge clk);
    push(1'b0, tag);
  endtask

  task automatic done(input string tag);
    @(negedge clk);
    xfer_done = 1'b1;
    @(posedge clk);
    m_busy = 1'b0;
    push(1'b0, tag);
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; xfer_done = 1'b0;
    adr_mode = 2'd0; dat_mode = 2'd0; fn_mode = 2'd1;
    m_busy = 1'b0; m_modes = 6'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    push(1'b0, "R10 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: no address, read mode
    set_modes(2'd0, 2'd1, 2'd1);
    wr(2'd2, 1'b0, "R4 alt write no launch");
    wr(2'd1, 1'b0, "R11 address write with no address phase");
    wr(2'd3, 1'b0, "R11 data write in read mode");
    wr(2'd0, 1'b1, "R1 instruction launch");
    idle("R5 start dropped, busy held");
    wr(2'd0, 1'b0, "R7 instruction write while busy");
    set_modes(2'd3, 2'd2, 2'd0);
    idle("R8 mode change after launch no effect");
    wr(2'd3, 1'b0, "R7 data write while busy with new modes");
    idle("R6 busy held without completion");
    done("R6 completion clears busy");
    done("R6 completion while idle no effect");

    // R1: no address, write mode with no data phase
    set_modes(2'd0, 2'd0, 2'd0);
    wr(2'd0, 1'b1, "R1 instruction launch, write mode no data");
    done("R6 clear");

    // R2: address, no data phase, write mode
    set_modes(2'd1, 2'd0, 2'd0);
    wr(2'd0, 1'b0, "R11 instruction write with address phase");
    wr(2'd2, 1'b0, "R4 alt write with address phase");
    wr(2'd1, 1'b1, "R2 address launch");
    wr(2'd1, 1'b0, "R7 address write while busy");
    done("R6 clear");

    // R2: address, data phase, read mode
    set_modes(2'd2, 2'd1, 2'd1);
    wr(2'd3, 1'b0, "R11 data write in read mode with address");
    wr(2'd1, 1'b1, "R2 address launch in read mode");
    done("R6 clear");

    // R3: address and firmware data
    set_modes(2'd3, 2'd3, 2'd0);
    wr(2'd1, 1'b0, "R11 address write when data needed");
    wr(2'd0, 1'b0, "R11 instruction write when data needed");
    wr(2'd2, 1'b0, "R4 alt write when data needed");
    wr(2'd3, 1'b1, "R3 data launch");
    set_modes(2'd0, 2'd0, 2'd1);
    wr(2'd0, 1'b0, "R7 R8 write while busy with new modes");
    done("R6 clear");

    // R9: no address, firmware data
    set_modes(2'd0, 2'd2, 2'd0);
    wr(2'd0, 1'b0, "R11 instruction write when data needed");
    wr(2'd1, 1'b0, "R11 address write with no address phase");
    wr(2'd3, 1'b1, "R9 data launch without address");
    idle("R5 single pulse");

    // R10: reset in the middle of a command
    @(negedge clk);
    rst_n = 1'b0;
    m_busy = 1'b0; m_modes = 6'd0;
    @(negedge clk);
    push(1'b0, "R10 reset clears busy and modes");
    @(negedge clk);
    rst_n = 1'b1;
    set_modes(2'd0, 2'd0, 2'd1);
    wr(2'd0, 1'b1, "R10 launch after reset");

    @(negedge clk);
    @(negedge clk);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule